// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer with Register Arbitration

This block is the digital half of a 10-bit successive-approximation converter with four selectable analog inputs. Software sets a start bit and a comparator-enable bit in a mode register and picks an input in a channel register. The block then waits a short start delay, holds a sampling phase, and runs ten bit trials, MSB first. During the trials it drives a trial code to an external resistor-string DAC and reads back a single comparator decision. The analog parts stay outside: the converter front end samples the input selected by `chan_sel` while `sampling` is high.

A finished result goes into a read-only result register, raises a one-cycle interrupt pulse and sets a sticky request flag. The block also settles collisions between that update and bus traffic that land in the same cycle. A result read delays the update by one cycle. A configuration write discards the update. A warm-up counter tracks the comparator after it is enabled. A conversion started too early, or with the comparator off, marks its first result as suspect.

Register map, selected by `bus_addr`:

- 0, mode: bit 0 is start, bit 1 is comparator enable.
- 1, channel: bits 1:0 select the input.
- 2, result: bits 9:0, read-only.
- 3, status: bit 0 is the request flag, bit 1 is the suspect mark.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Each conversion tests ten bits MSB first. A bit under trial is kept when `cmp_hi` is 1 and cleared when it is 0. With a comparator that reports input >= trial code, the stored result equals the input code, including 0x000 and 0x3FF.
- R2: A conversion is 10 sampling cycles with `sampling` high, followed by 10 trials of 5 cycles each. The interrupt pulse appears in the cycle after the 60th conversion cycle.
- R3: When a bus read of address 2 falls in the last conversion cycle, the read returns the old result. The new result and the interrupt pulse appear one cycle later than usual.
- R4: When a write to address 0 or 1 falls in the last conversion cycle, that result is discarded. The result register keeps its value and no interrupt pulse is produced.
- R5: A write to address 1 leaves the request flag (status bit 0) unchanged.
- R6: Every stored result gives a one-cycle high pulse on `irq` and sets status bit 0. Writing 0 to status bit 0 clears it. Writing 1 has no effect.
- R7: While start (mode bit 0) stays 1, a new sampling phase begins right after each result. Writing start = 0 aborts the conversion, with no result update and no interrupt.
- R8: A write to address 0 with start = 1, or to address 1 while start is 1, restarts the sequence from the start delay. The sequence then uses the newly written channel, which `chan_sel` shows from the next cycle.
- R9: When start goes from 0 to 1 with the comparator enable (mode bit 1) off, or before WARM_CYC cycles have passed since it was enabled, the first stored result sets status bit 1. Every later result clears that bit.
- R10: Sampling begins START_DLY cycles after the clock edge that takes a start or restart write.
- R11: After reset every register reads 0, `irq` and `sampling` are low, and reads use the map given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (matters only for collision rules) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| cmp_hi | input | 1 | Comparator decision: analog input >= DAC level |
| trial_code | output | 10 | Code driven to the DAC during bit trials |
| chan_sel | output | 2 | Selected analog input |
| sampling | output | 1 | High during the sampling phase |
| irq | output | 1 | One-cycle pulse per stored result |

## Verification
Conversions are run on mid-scale, all-zero and all-one input codes. A fault in the per-bit keep/clear decision or in the bit order shows up as a wrong code, and the all-zero and all-one codes expose errors at the ends of the trial code. Bus reads and configuration writes are placed exactly on the last conversion cycle and also in the middle of a conversion. This tells the one-cycle deferral apart from the drop, and either of those apart from an ordinary restart. Starts are issued with the comparator off, together with enabling it, and after it has warmed up, so that the suspect mark is tied to the first result only.

// File: rtl/sar_pkg.sv
// Shared types for the SAR conversion sequencer.
// Assumes a 2-bit register address space, decoded by sar_regs.
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_SAMPLE,
        ST_TRIAL
    } seq_state_t;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_CHAN = 2'd1;
    localparam logic [1:0] ADDR_RES  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;
endpackage

// File: rtl/sar_seq.sv
// Conversion sequencer: start delay, sampling phase, and RES_W bit
// trials, MSB first. It reports the last trial cycle through eoc and
// gives the finished code in that same cycle.
// Assumes go and halt are never high together, and halt has priority.
module sar_seq
    import sar_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int SAMPLE_CYC = 10,
    parameter int TRIAL_CYC  = 5,
    parameter int START_DLY  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             halt,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial_code,
    output logic             smp_en,
    output logic             eoc,
    output logic [RES_W-1:0] eoc_code
);
    localparam int MAX_PH = (SAMPLE_CYC > TRIAL_CYC)
                          ? ((SAMPLE_CYC > START_DLY) ? SAMPLE_CYC : START_DLY)
                          : ((TRIAL_CYC > START_DLY) ? TRIAL_CYC : START_DLY);
    localparam int CNT_W = $clog2(MAX_PH + 1);
    localparam int BIT_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [CNT_W-1:0] LAST_DLY = CNT_W'(START_DLY - 1);
    localparam logic [CNT_W-1:0] LAST_SMP = CNT_W'(SAMPLE_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_TRL = CNT_W'(TRIAL_CYC - 1);
    localparam logic [RES_W-1:0] MSB_ONE  = RES_W'(1) << (RES_W - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [BIT_W-1:0] bit_idx;
    logic [RES_W-1:0] code;
    logic [CNT_W-1:0] last_cnt;
    logic             phase_end;
    logic [RES_W-1:0] decided;

    // Length of the phase that is running now.
    always_comb begin
        case (state)
            ST_DELAY:  last_cnt = LAST_DLY;
            ST_SAMPLE: last_cnt = LAST_SMP;
            default:   last_cnt = LAST_TRL;
        endcase
    end

    assign phase_end = (state != ST_IDLE) && (cnt == last_cnt);

    // The trial code with the bit under test replaced by the comparator decision.
    always_comb begin
        decided          = code;
        decided[bit_idx] = cmp_in;
    end

    assign eoc        = (state == ST_TRIAL) && phase_end && (bit_idx == '0);
    assign eoc_code   = decided;
    assign trial_code = code;
    assign smp_en     = (state == ST_SAMPLE);

    // Phase sequencing and successive-approximation register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            code    <= '0;
        end else if (halt) begin
            state <= ST_IDLE;
            cnt   <= '0;
            code  <= '0;
        end else if (go) begin
            state <= ST_DELAY;
            cnt   <= '0;
            code  <= '0;
        end else if (state != ST_IDLE) begin
            if (!phase_end) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                case (state)
                    ST_DELAY: state <= ST_SAMPLE;
                    ST_SAMPLE: begin
                        state   <= ST_TRIAL;
                        bit_idx <= BIT_W'(RES_W - 1);
                        code    <= MSB_ONE;
                    end
                    default: begin
                        if (bit_idx == '0) begin
                            state <= ST_SAMPLE;
                            code  <= '0;
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                            code    <= decided | (RES_W'(1) << (bit_idx - 1'b1));
                        end
                    end
                endcase
            end
        end
    end

    // R7: an abort always leaves the sequencer idle.
    p_halt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (state == ST_IDLE));

    // R8: a restart without abort re-enters the start delay.
    p_go_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !halt) |=> (state == ST_DELAY));

    // R7: a finished conversion without bus interference samples again.
    p_eoc_resample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && !go && !halt) |=> (state == ST_SAMPLE && cnt == '0));

    // R2: the sampling output never overlaps a trial code.
    p_sample_no_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en |-> (trial_code == '0));
endmodule

// File: rtl/sar_regs.sv
// Register file and arbiter. It holds the mode, channel, result and
// status registers, the comparator warm-up counter, and the rules for
// a result update that meets a bus read or a configuration write.
// Assumes bus_rd only affects the collision rule; rdata is combinational.
module sar_regs
    import sar_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int N_CH     = 4,
    parameter int DATA_W   = 16,
    parameter int WARM_CYC = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [1:0]               addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic                     eoc,
    input  logic [RES_W-1:0]         eoc_code,
    output logic [$clog2(N_CH)-1:0]  ch,
    output logic                     go,
    output logic                     halt,
    output logic                     irq
);
    localparam int CH_W   = $clog2(N_CH);
    localparam int WARM_W = $clog2(WARM_CYC + 1);
    localparam logic [WARM_W-1:0] WARM_END = WARM_W'(WARM_CYC);

    logic              start_q, en_q, flag_q, susp_q, arm_q, pend_q, irq_q;
    logic [CH_W-1:0]   ch_q;
    logic [RES_W-1:0]  res_q, pend_val_q;
    logic [WARM_W-1:0] wcnt_q;
    logic              wr_mode, wr_chan, wr_stat, rd_res, cfg_wr;
    logic              new_start, start_rise, warm_done, commit;
    logic [RES_W-1:0]  commit_val;

    assign wr_mode    = wr_en && (addr == ADDR_MODE);
    assign wr_chan    = wr_en && (addr == ADDR_CHAN);
    assign wr_stat    = wr_en && (addr == ADDR_STAT);
    assign rd_res     = rd_en && (addr == ADDR_RES);
    assign cfg_wr     = wr_mode || wr_chan;
    assign new_start  = wr_mode ? wdata[0] : start_q;
    assign go         = cfg_wr && new_start;
    assign halt       = wr_mode && !wdata[0];
    assign start_rise = wr_mode && wdata[0] && !start_q;
    assign warm_done  = (wcnt_q == WARM_END);
    assign commit     = pend_q || (eoc && !cfg_wr && !rd_res);
    assign commit_val = pend_q ? pend_val_q : eoc_code;
    assign ch         = ch_q;
    assign irq        = irq_q;

    // Mode and channel registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            en_q    <= 1'b0;
            ch_q    <= '0;
        end else begin
            if (wr_mode) begin
                start_q <= wdata[0];
                en_q    <= wdata[1];
            end
            if (wr_chan) ch_q <= wdata[CH_W-1:0];
        end
    end

    // Comparator warm-up counter, saturating, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_q) wcnt_q <= '0;
        else if (!warm_done) wcnt_q <= wcnt_q + 1'b1;
    end

    // One-cycle deferral of a result that meets a result read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_val_q <= '0;
        end else begin
            pend_q <= eoc && !cfg_wr && rd_res;
            if (eoc) pend_val_q <= eoc_code;
        end
    end

    // Result register and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= commit;
            if (commit) res_q <= commit_val;
        end
    end

    // Request flag: set by a result, cleared only by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else if (commit) flag_q <= 1'b1;
        else if (wr_stat && !wdata[0]) flag_q <= 1'b0;
    end

    // Suspect tracking: armed on a start edge, consumed by the next result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q  <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            if (commit) begin
                susp_q <= arm_q;
                arm_q  <= 1'b0;
            end
            if (start_rise) arm_q <= !(en_q && wdata[1] && warm_done);
        end
    end

    // Register read mux.
    always_comb begin
        case (addr)
            ADDR_MODE: rdata = DATA_W'({en_q, start_q});
            ADDR_CHAN: rdata = DATA_W'(ch_q);
            ADDR_RES:  rdata = DATA_W'(res_q);
            default:   rdata = DATA_W'({susp_q, flag_q});
        endcase
    end

    // R3: a colliding read sees no update and no pulse in the next cycle.
    p_read_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && rd_res && !cfg_wr) |=> ($stable(res_q) && !irq_q));

    // R3: the deferred result arrives one cycle later.
    p_read_late_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && rd_res && !cfg_wr) |-> ##2 irq_q);

    // R4: a colliding configuration write drops the result.
    p_cfg_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && cfg_wr) |=> (!irq_q && $stable(res_q)));

    // R5: a channel write keeps a set request flag.
    p_chan_keeps_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_chan && flag_q) |=> flag_q);

    // R6: the interrupt is a single-cycle pulse and is mirrored in the flag.
    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> flag_q);
endmodule

// File: rtl/sar_adc_ctrl.sv
// Top level of the SAR conversion controller. Connects the register
// arbiter to the phase sequencer. The comparator and DAC are external.
// Assumes a single clock domain and a synchronous active-low reset.
module sar_adc_ctrl #(
    parameter int RES_W      = 10,
    parameter int N_CH       = 4,
    parameter int DATA_W     = 16,
    parameter int SAMPLE_CYC = 10,
    parameter int TRIAL_CYC  = 5,
    parameter int START_DLY  = 2,
    parameter int WARM_CYC   = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [1:0]              bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic                    cmp_hi,
    output logic [RES_W-1:0]        trial_code,
    output logic [$clog2(N_CH)-1:0] chan_sel,
    output logic                    sampling,
    output logic                    irq
);
    logic             go, halt, eoc;
    logic [RES_W-1:0] eoc_code;

    sar_regs #(
        .RES_W(RES_W), .N_CH(N_CH), .DATA_W(DATA_W), .WARM_CYC(WARM_CYC)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata),
        .eoc(eoc), .eoc_code(eoc_code),
        .ch(chan_sel), .go(go), .halt(halt), .irq(irq)
    );

    sar_seq #(
        .RES_W(RES_W), .SAMPLE_CYC(SAMPLE_CYC),
        .TRIAL_CYC(TRIAL_CYC), .START_DLY(START_DLY)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .go(go), .halt(halt), .cmp_in(cmp_hi),
        .trial_code(trial_code), .smp_en(sampling),
        .eoc(eoc), .eoc_code(eoc_code)
    );
endmodule

// File: tb/tb_sar_adc_ctrl.sv
// Testbench: a behavioural model driven by a conversion-time integer,
// compared with the design on every cycle, plus directed checks.
module tb_sar_adc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SMP   = 10;
    localparam int TRL   = 5;
    localparam int DLY   = 2;
    localparam int WARM  = 20;
    localparam int TOTAL = SMP + 10 * TRL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bwr = 1'b0, brd = 1'b0;
    logic [1:0]  baddr = 2'd0;
    logic [15:0] bwd = '0;
    logic [15:0] rdata;
    logic [9:0]  trial_code;
    logic [1:0]  chan_sel;
    logic        sampling, irq, cmp_hi;
    logic [9:0]  ain [4];

    int errors = 0, checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign cmp_hi = (ain[chan_sel] >= trial_code);

    sar_adc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bwr), .bus_rd(brd),
        .bus_addr(baddr), .bus_wdata(bwd), .bus_rdata(rdata),
        .cmp_hi(cmp_hi), .trial_code(trial_code), .chan_sel(chan_sel),
        .sampling(sampling), .irq(irq)
    );

    // Reference model state.
    bit m_run, m_start, m_en, m_flag, m_susp, m_arm, m_pend, m_irq, m_commit;
    int m_t, m_ch, m_res, m_pv, m_wcnt, m_cval;
    bit wm, wc, ws, rr, eoc_m;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_start = 0; m_en = 0; m_flag = 0; m_susp = 0;
            m_arm = 0; m_pend = 0; m_irq = 0; m_t = 0; m_ch = 0;
            m_res = 0; m_pv = 0; m_wcnt = 0;
        end else begin
            wm = bwr && baddr == 2'd0;
            wc = bwr && baddr == 2'd1;
            ws = bwr && baddr == 2'd3;
            rr = brd && baddr == 2'd2;
            eoc_m = m_run && m_t == TOTAL - 1;
            m_commit = 0;
            if (m_pend) begin m_commit = 1; m_cval = m_pv; end
            m_pend = 0;
            if (eoc_m && !(wm || wc)) begin
                if (rr) begin m_pend = 1; m_pv = ain[m_ch]; end
                else begin m_commit = 1; m_cval = ain[m_ch]; end
            end
            if (m_commit) begin m_susp = m_arm; m_arm = 0; m_res = m_cval; end
            if (wm && bwd[0] && !m_start) m_arm = !(m_en && bwd[1] && m_wcnt == WARM);
            if (ws && !bwd[0]) m_flag = 0;
            if (m_commit) m_flag = 1;
            m_irq = m_commit;
            if (!m_en) m_wcnt = 0; else if (m_wcnt < WARM) m_wcnt++;
            if (wm && !bwd[0]) m_run = 0;
            else if ((wm || wc) && (wm ? bwd[0] : m_start)) begin m_run = 1; m_t = -DLY; end
            else if (m_run) m_t = (m_t == TOTAL - 1) ? 0 : m_t + 1;
            if (wm) begin m_start = bwd[0]; m_en = bwd[1]; end
            if (wc) m_ch = int'(bwd[1:0]);
        end
    end

    function automatic int exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {m_en, m_start};
            2'd1: return m_ch;
            2'd2: return m_res;
            default: return {m_susp, m_flag};
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive inputs, then compare against the model.
    task automatic step(input bit w, input bit r, input logic [1:0] a, input int d);
        @(negedge clk);
        bwr = w; brd = r; baddr = a; bwd = 16'(d);
        #1;
        if (rst_n) begin
            chk("R6 irq", int'(irq), int'(m_irq));
            chk("R2 sampling", int'(sampling), int'(m_run && m_t >= 0 && m_t < SMP));
            chk("R8 chan_sel", int'(chan_sel), m_ch);
            chk("R11 rdata", int'(rdata), exp_rd(a));
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 2'd0, 0);
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        step(1, 0, a, d);
    endtask

    // Read a register in its own idle cycle.
    task automatic rd(input logic [1:0] a, output int v);
        step(0, 1, a, 0);
        v = int'(rdata);
    endtask

    // Cycles until the irq pulse is observed.
    task automatic wait_irq(output int n);
        n = 0;
        do begin idle(1); n++; end while (!irq && n < 300);
    endtask

    // Advance until the model sits at conversion cycle t.
    task automatic wait_t(input int t);
        int g = 0;
        while (!(m_run && m_t == t) && g < 300) begin idle(1); g++; end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v, n;
        ain[0] = 10'h2A5; ain[1] = 10'h0F3; ain[2] = 10'h000; ain[3] = 10'h155;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        // R11: reset values of all registers and outputs.
        for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R11 reset", v, 0); end
        chk("R11 irq low", int'(irq), 0);

        // R1 R2 R10: warm comparator, then a conversion on channel 0.
        wr(2'd0, 2); idle(30);
        wr(2'd0, 3);
        wait_irq(n);
        chk("R2 R10 latency", n, DLY + TOTAL + 1);
        rd(2'd2, v); chk("R1 mid-scale code", v, 10'h2A5);
        rd(2'd3, v); chk("R9 warm start not suspect", v, 1);
        // R7: continuous conversion.
        wait_irq(n); chk("R7 back-to-back period", n, TOTAL - 2);

        // R6: writing 1 keeps the flag, writing 0 clears it.
        wr(2'd3, 1); rd(2'd3, v); chk("R6 write 1 no effect", v & 1, 1);
        wr(2'd3, 0); rd(2'd3, v); chk("R6 write 0 clears", v & 1, 0);

        // R8: channel change mid-conversion restarts on the new input.
        wait_t(20);
        wr(2'd1, 1);
        wait_irq(n);
        chk("R8 restart latency", n, DLY + TOTAL + 1);
        rd(2'd2, v); chk("R8 new channel result", v, 10'h0F3);

        // R5: channel write does not clear the flag.
        wr(2'd1, 2);
        rd(2'd3, v); chk("R5 flag kept", v & 1, 1);

        // R3: read collision on the last conversion cycle (input 0x000).
        wait_t(TOTAL - 2);
        step(0, 1, 2'd2, 0);
        chk("R3 old value on collision", int'(rdata), 10'h0F3);
        rd(2'd2, v); chk("R3 still old next cycle", v, 10'h0F3);
        chk("R3 no pulse yet", int'(irq), 0);
        rd(2'd2, v); chk("R1 zero code deferred", v, 10'h000);
        chk("R3 late pulse", int'(irq), 1);

        // R4: configuration write on the last conversion cycle drops the result.
        ain[2] = 10'h3FF;
        wait_t(TOTAL - 2);
        wr(2'd0, 3);
        rd(2'd2, v); chk("R4 result kept", v, 10'h000);
        chk("R4 no pulse", int'(irq), 0);
        wait_irq(n);
        chk("R4 next result after restart", n, DLY + TOTAL);
        rd(2'd2, v); chk("R1 full-scale code", v, 10'h3FF);

        // R7: abort mid-conversion produces nothing.
        wait_t(30);
        wr(2'd0, 2);
        n = 0;
        for (int i = 0; i < 150; i++) begin idle(1); n += int'(irq); end
        chk("R7 abort no irq", n, 0);
        rd(2'd2, v); chk("R7 abort keeps result", v, 10'h3FF);

        // R9: start with comparator disabled.
        wr(2'd0, 0); wr(2'd3, 0); wr(2'd1, 3);
        wr(2'd0, 1);
        wait_irq(n);
        rd(2'd2, v); chk("R1 channel 3 code", v, 10'h155);
        rd(2'd3, v); chk("R9 disabled start suspect", v, 3);
        wait_irq(n);
        rd(2'd3, v); chk("R9 second result clean", v, 1);

        // R9: enable and start together.
        wr(2'd0, 0); idle(5);
        wr(2'd0, 3);
        wait_irq(n);
        rd(2'd3, v); chk("R9 simultaneous enable suspect", v, 3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule